// File: doc/BRIEF.md
# Serial-Load Bank Register Interface

This block is the write side of a memory-bank controller whose configuration registers are filled one bit per processor write. Every write to the upper half of the address space carries one useful data bit, bit 0. The bits build up in a shift register with the least significant bit arriving first. When the fifth bit arrives, the assembled value is stored in one of four registers, chosen by address bits 14:13. Register 0 is the control register. The other three hold bank numbers that a separate decoder uses.

Two protections guard the loader. A write with data bit 7 set acts as a loader reset: it discards any partial value and forces the control register's two program-mode bits (mask 0x0C) high. A short guard window rejects bit-load writes that follow the previous upper-half write too closely. Any upper-half write, whether accepted or not, reloads a guard counter to 2. The counter counts down once per processor-cycle tick.

Top module: `serial_bank_loader`

## Requirements
- R1: After reset, the control register (index 0) reads 0x0C and registers 1 to 3 read 0x00. No partial value is pending and the guard counter is zero.
- R2: An accepted bit-load write shifts in data bit 0, least significant bit first. The fifth accepted bit completes a 5-bit value, which appears on the port in the cycle after the clock edge that captured that write. The partial value and the bit count then clear.
- R3: The completed value goes to the register selected by address bits 14:13: 0 is control, and 1, 2 and 3 are the bank registers. Only that register changes.
- R4: A write with address bit 15 low is ignored completely. It shifts nothing, changes no register and does not reload the guard counter.
- R5: An upper-half write with data bit 7 set ORs 0x0C into the control register and keeps its other bits. It discards the partial value and bit count, and leaves registers 1 to 3 unchanged.
- R6: Every upper-half write loads the guard counter with 2, including rejected and reset writes. A write takes precedence over a tick in the same cycle. Otherwise the counter drops by one per tick while it is nonzero, and it holds when no tick occurs.
- R7: A bit-load write is accepted only when the guard counter is zero. A rejected write changes neither the partial value nor any register. With ticks every cycle, a bit-load write is accepted only if at least two idle cycles separate it from the previous upper-half write. Back-to-back writes therefore load only the first bit.
- R8: A reset write takes effect whatever the guard counter holds.
- R9: Data bits 6:1 have no effect on any loaded value.
- R10: Registers keep their values in every cycle without a commit or reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_tick_i | input | 1 | One pulse per processor cycle; decrements the guard counter |
| wr_en_i | input | 1 | Processor write strobe, one clock per write |
| wr_addr_i | input | ADDR_W (16) | Write address |
| wr_data_i | input | 8 | Write data |
| bank_regs_o | output | NUM_REGS*REG_W (20) | Register i occupies bits i*REG_W +: REG_W |

## Verification
Every register update is a single flop stage from the write strobe. A committed value or a forced control value is therefore visible in the first cycle after the capturing edge. The bench drives inputs on falling edges and samples on the falling edge that follows the capture, so it never reads a register before it changes or after a later write. The guard window counts in whole cycles: a write captured two edges after the previous write is rejected, and one captured three edges after it is accepted. The filter tests place writes on exactly those edges and give each ignored bit a value that would yield a different final register value if it had been taken.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  // Lowest address bit of the destination-register select field.
  localparam int unsigned SEL_LSB = 13;
  // Data bit that turns a write into a loader reset.
  localparam int unsigned RESET_BIT = 7;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_RESET = 2'd1,
    WR_LOAD  = 2'd2,
    WR_DROP  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/sbl_write_filter.sv
module sbl_write_filter #(
  parameter int unsigned FILTER_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic tick_i,
  output logic open_o
);
  localparam int unsigned FW = $clog2(FILTER_CYCLES + 1);

  logic [FW-1:0] filt_q, filt_d;
  logic          filt_en;

  always_comb begin
    filt_en = hit_i | (tick_i & (filt_q != '0));
    filt_d  = filt_q;
    if (hit_i)
      filt_d = FW'(FILTER_CYCLES);
    else if (tick_i && filt_q != '0)
      filt_d = filt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      filt_q <= '0;
    else if (filt_en)
      filt_q <= filt_d;
  end

  assign open_o = (filt_q == '0);

  assert_filter_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> filt_q == FW'(FILTER_CYCLES));
  assert_filter_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    filt_q <= FW'(FILTER_CYCLES));
  assert_filter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !tick_i) |=> $stable(filt_q));
endmodule

// File: rtl/sbl_shift_accum.sv
module sbl_shift_accum #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [REG_W-1:0] value_o
);
  localparam int unsigned CW = $clog2(REG_W);

  logic [REG_W-1:0] sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             en;

  assign done_o  = shift_i && (cnt_q == CW'(REG_W - 1));
  assign value_o = {bit_i, sh_q[REG_W-1:1]};

  always_comb begin
    en    = clear_i | shift_i;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clear_i || done_o) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (shift_i) begin
      sh_d  = {bit_i, sh_q[REG_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(REG_W));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0 && sh_q == '0));
  assert_no_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !shift_i) |=> ($stable(cnt_q) && $stable(sh_q)));
endmodule

// File: rtl/sbl_reg_bank.sv
module sbl_reg_bank #(
  parameter int unsigned NUM_REGS   = 4,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned CTRL_INIT  = 12,
  parameter int unsigned CTRL_FORCE = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit_i,
  input  logic [$clog2(NUM_REGS)-1:0] sel_i,
  input  logic [REG_W-1:0]          value_i,
  input  logic                      force_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);
  localparam logic [REG_W-1:0] FORCE_MASK = REG_W'(CTRL_FORCE);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] INIT = (g == 0) ? REG_W'(CTRL_INIT) : '0;
    localparam bit IS_CTRL = (g == 0);
    logic [REG_W-1:0] q, d;
    logic             wr, en;

    always_comb begin
      wr = commit_i && (sel_i == SEL_W'(g));
      en = wr || (force_i && IS_CTRL);
      d  = q;
      if (wr)
        d = value_i;
      else if (force_i && IS_CTRL)
        d = q | FORCE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= INIT;
      else if (en)
        q <= d;
    end

    assign regs_o[g*REG_W +: REG_W] = q;
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i && !force_i) |=> $stable(regs_o));
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader #(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned NUM_REGS      = 4,
  parameter int unsigned REG_W         = 5,
  parameter int unsigned FILTER_CYCLES = 2,
  parameter int unsigned CTRL_INIT     = 12,
  parameter int unsigned CTRL_FORCE    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_tick_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [7:0]                wr_data_i,
  output logic [NUM_REGS*REG_W-1:0] bank_regs_o
);
  import sbl_pkg::*;

  localparam int unsigned SEL_W = $clog2(NUM_REGS);
  localparam logic [REG_W-1:0] FORCE_MASK = REG_W'(CTRL_FORCE);

  logic             hit, open, done;
  logic [SEL_W-1:0] sel;
  logic [REG_W-1:0] value;
  wr_kind_e         kind;
  logic             unused_bits;

  assign hit = wr_en_i & wr_addr_i[ADDR_W-1];
  assign sel = wr_addr_i[SEL_LSB +: SEL_W];
  assign unused_bits = ^{wr_addr_i, wr_data_i};

  always_comb begin
    kind = WR_NONE;
    if (hit) begin
      if (wr_data_i[RESET_BIT])
        kind = WR_RESET;
      else if (open)
        kind = WR_LOAD;
      else
        kind = WR_DROP;
    end
  end

  sbl_write_filter #(.FILTER_CYCLES(FILTER_CYCLES)) filt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .tick_i (cpu_tick_i),
    .open_o (open)
  );

  sbl_shift_accum #(.REG_W(REG_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (kind == WR_RESET),
    .shift_i (kind == WR_LOAD),
    .bit_i   (wr_data_i[0]),
    .done_o  (done),
    .value_o (value)
  );

  sbl_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .REG_W     (REG_W),
    .CTRL_INIT (CTRL_INIT),
    .CTRL_FORCE(CTRL_FORCE)
  ) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_i (done),
    .sel_i    (sel),
    .value_i  (value),
    .force_i  (kind == WR_RESET),
    .regs_o   (bank_regs_o)
  );

  assert_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_RESET) |=> ((bank_regs_o[REG_W-1:0] & FORCE_MASK) == FORCE_MASK));
  assert_force_keeps_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == WR_RESET) |=> $stable(bank_regs_o[NUM_REGS*REG_W-1:REG_W]));
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !wr_data_i[RESET_BIT] && !open) |=> $stable(bank_regs_o));
  assert_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_addr_i[ADDR_W-1]) |=> $stable(bank_regs_o));
  assert_reset_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr_data_i[RESET_BIT]) |-> kind == WR_RESET);
endmodule

// File: tb/serial_bank_loader_tb_top.sv
module serial_bank_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_en;
  logic [15:0] addr;
  logic [7:0]  data;
  logic [19:0] regs;

  int checks = 0;
  int errors = 0;
  logic [4:0] exp_r [4];

  always #2 clk = ~clk;

  serial_bank_loader dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(addr), .wr_data_i(data), .bank_regs_o(regs)
  );

  // {select[6:5], value[4:0]}
  localparam logic [6:0] VEC [8] = '{
    {2'd1, 5'h15}, {2'd2, 5'h0A}, {2'd3, 5'h1F}, {2'd0, 5'h03},
    {2'd1, 5'h00}, {2'd3, 5'h11}, {2'd2, 5'h1E}, {2'd0, 5'h10}
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 4; i++) check(req, regs[i*5 +: 5], exp_r[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 16'h0000; data = 8'h00;
  endtask

  function automatic logic [15:0] sel_addr(input logic [1:0] s);
    return {1'b1, s, 13'h0A5};
  endfunction

  // Full five-bit load, two idle cycles between writes, junk in bits 6:1 (R9).
  task automatic load(input logic [1:0] s, input logic [4:0] v);
    for (int b = 0; b < 5; b++) begin
      wr(sel_addr(s), {1'b0, 6'(6'h2A ^ b), v[b]});
      if (b < 4) idle(2);
    end
    exp_r[s] = v;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; addr = '0; data = '0;
    exp_r[0] = 5'h0C; exp_r[1] = 5'h00; exp_r[2] = 5'h00; exp_r[3] = 5'h00;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check_all("R1 reset values");

    // Vector table: R2 assembly, R3 destination, R9 junk bits.
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][6:5], VEC[i][4:0]);
      check_all("R2/R3/R9 vector load");
      idle(2);
    end

    // R7/R8-style back-to-back: bits 1,(0 rejected),1,0,1,1 -> 0x1B
    wr(sel_addr(2'd1), 8'h01);
    wr(sel_addr(2'd1), 8'h00);
    check_all("R7 rejected write leaves registers");
    idle(2);
    wr(sel_addr(2'd1), 8'h01); idle(2);
    wr(sel_addr(2'd1), 8'h00); idle(2);
    wr(sel_addr(2'd1), 8'h01); idle(2);
    wr(sel_addr(2'd1), 8'h01);
    exp_r[1] = 5'h1B;
    check_all("R7 back-to-back loads only first bit");
    idle(2);

    // R6 rejected write reloads guard: 1, drop(0) after 1 idle, drop(0) after 1 idle, then 0,1,1,1 -> 0x1D
    wr(sel_addr(2'd3), 8'h01); idle(1);
    wr(sel_addr(2'd3), 8'h00); idle(1);
    wr(sel_addr(2'd3), 8'h00); idle(2);
    wr(sel_addr(2'd3), 8'h00); idle(2);
    wr(sel_addr(2'd3), 8'h01); idle(2);
    wr(sel_addr(2'd3), 8'h01); idle(2);
    wr(sel_addr(2'd3), 8'h01);
    exp_r[3] = 5'h1D;
    check_all("R6 rejected write reloads guard");
    idle(2);

    // R6 no tick: guard holds, write after 6 idle cycles still rejected -> 0x1D
    tick = 1'b0;
    wr(sel_addr(2'd2), 8'h01); idle(6);
    wr(sel_addr(2'd2), 8'h00);
    tick = 1'b1; idle(2);
    wr(sel_addr(2'd2), 8'h00); idle(2);
    wr(sel_addr(2'd2), 8'h01); idle(2);
    wr(sel_addr(2'd2), 8'h01); idle(2);
    wr(sel_addr(2'd2), 8'h01);
    exp_r[2] = 5'h1D;
    check_all("R6 guard holds without ticks");
    idle(2);

    // R4 lower-half write: no shift, no guard reload -> bits 1,0,1,1,1 = 0x1D
    wr(sel_addr(2'd1), 8'h01); idle(2);
    wr(16'h6000, 8'h81);
    check_all("R4 lower-half write changes nothing");
    wr(sel_addr(2'd1), 8'h00); idle(2);
    wr(sel_addr(2'd1), 8'h01); idle(2);
    wr(sel_addr(2'd1), 8'h01); idle(2);
    wr(sel_addr(2'd1), 8'h01);
    exp_r[1] = 5'h1D;
    check_all("R4 lower-half write leaves guard and shift");
    idle(2);

    // R5/R8: control 0x01, partial load, immediate reset write
    load(2'd0, 5'h01);
    check_all("R2 control load");
    idle(2);
    wr(sel_addr(2'd2), 8'h01);
    wr(16'h8000, 8'h80);
    exp_r[0] = 5'h0D;
    check_all("R5 R8 reset write forces mode bits inside guard");
    idle(2);
    load(2'd2, 5'h06);
    check_all("R5 partial value discarded");
    idle(2);

    // R10: idle cycles with ticks keep everything
    idle(10);
    check_all("R10 registers hold");

    // R1 again after a mid-run reset
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    exp_r[0] = 5'h0C; exp_r[1] = 5'h00; exp_r[2] = 5'h00; exp_r[3] = 5'h00;
    check_all("R1 reset after activity");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule